// File: doc/BRIEF.md
# Link Error Reporting Controller

This block sits on the receiving side of a serial video link. It counts decode errors, parity errors and pattern-test mismatches into three saturating error registers and drives one active-low error status output. Both the line decoder and an external pattern comparator report into it through one-cycle strobes. It also watches which phase the link is in: video, control channel or bypass.

The decode and parity registers have two ways to clear. A register read clears them by default. When the auto-clear option is set, they also clear at the end of each control channel phase. The pattern-test register ignores both of these and clears only when the pattern test is switched off. The status output stays low while any error class is pending. Each class releases it on its own rule, so the output goes high again as soon as the last pending class is gone.

Top module: `link_err_ctrl`

## Requirements
- R1: Each cycle with `dec_err_i` high adds one to `dec_cnt_o`, visible after the next rising clock edge.
- R2: A read strobe (`rd_dec_i` or `rd_par_i`) clears its register at the next edge. If an error event of that class arrives in the same cycle, the register ends at 1.
- R3: With no read and `auto_clr_i` at 0, a control channel phase does not change the decode or parity count, and later errors add to the previous count.
- R4: With `auto_clr_i` at 1, the decode and parity registers clear at the edge that samples `ctrl_ph_i` low for the first time after it was high. An event in that same cycle leaves a count of 1.
- R5: The auto-clear never changes `prbs_cnt_o`.
- R6: While `prbs_en_i` is 1, each cycle with `prbs_mis_i` high adds one to `prbs_cnt_o`. While `prbs_en_i` is 0, mismatch strobes have no effect.
- R7: `prbs_en_i` at 0 clears `prbs_cnt_o` at the next edge. `err_n_o` rises in that same update if pattern errors were its only cause.
- R8: `err_n_o` is 0 whenever `dec_cnt_o` or `prbs_cnt_o` is nonzero, or a parity error is flagged. Otherwise it is 1.
- R9: In bypass mode (`bypass_i` = 1) with `auto_clr_i` at 0, parity errors still count but do not drive `err_n_o` low.
- R10: In bypass mode with `auto_clr_i` at 1, a parity error drives `err_n_o` low. The flag releases at the edge where `video_ph_i` is first sampled high after being low, and the parity count is kept.
- R11: Every register saturates at 2^CNT_W-1 and does not wrap.
- R12: After reset, all counts are 0 and `err_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_err_i | input | 1 | Decode error strobe, one per word |
| par_err_i | input | 1 | Parity error strobe, one per word |
| prbs_mis_i | input | 1 | Pattern-test mismatch strobe |
| video_ph_i | input | 1 | Link is in the video phase |
| ctrl_ph_i | input | 1 | Link is in the control channel phase |
| bypass_i | input | 1 | Bypass mode active |
| prbs_en_i | input | 1 | Pattern-test enable bit |
| auto_clr_i | input | 1 | Clear decode/parity registers at the end of the control channel |
| rd_dec_i | input | 1 | Read strobe of the decode register |
| rd_par_i | input | 1 | Read strobe of the parity register |
| dec_cnt_o | output | CNT_W | Decode error register |
| par_cnt_o | output | CNT_W | Parity error register |
| prbs_cnt_o | output | CNT_W | Pattern-test error register |
| err_n_o | output | 1 | Active-low error status |

## Verification
The assertions assume that strobes and phase levels are synchronous to `clk` and are held for whole cycles. They also assume that the pattern-test enable is a level, not a pulse. The bench drives every input on the falling edge from one driver task, so each input is stable across the sampling edge. A reference model inside that task predicts every count and the status output for each cycle. The stimulus includes reads that coincide with events, events that land on the control channel end, and a run long enough to reach saturation.

// File: rtl/lerr_pkg.sv
package lerr_pkg;
   function automatic logic [31:0] sat_max(input int w);
      return (32'd1 << w) - 32'd1;
   endfunction
endpackage

// File: rtl/lerr_sat_cnt.sv
module lerr_sat_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o
);
   localparam logic [W-1:0] MAX = W'(lerr_pkg::sat_max(W));

   initial begin
      if (W < 2 || W > 31) $error("lerr_sat_cnt: W out of range");
   end

   logic [W-1:0] cnt_q, cnt_d;

   always_comb begin
      cnt_d = cnt_q;
      if (clr_i)                     cnt_d = inc_i ? W'(1) : '0;
      else if (inc_i && cnt_q != MAX) cnt_d = cnt_q + W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign cnt_o = cnt_q;

   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == MAX && inc_i && !clr_i) |=> cnt_q == MAX); // R11
   AST_CLR_SEEDS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> cnt_q <= W'(1)); // R2
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !clr_i && cnt_q != MAX) |=> cnt_q == $past(cnt_q) + W'(1)); // R1
endmodule

// File: rtl/lerr_edge.sv
module lerr_edge #(
   parameter bit RISE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_i,
   output logic edge_o
);
   logic sig_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sig_q <= 1'b0;
      else        sig_q <= sig_i;
   end

   generate
      if (RISE) begin : g_rise
         assign edge_o = sig_i & ~sig_q;
      end else begin : g_fall
         assign edge_o = ~sig_i & sig_q;
      end
   endgenerate
endmodule

// File: rtl/lerr_par_flag.sv
module lerr_par_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic byp_i,
   input  logic clr_i,
   input  logic vid_rise_i,
   output logic flag_o
);
   logic flag_q, src_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         src_q  <= 1'b0;
      end else if (clr_i) begin
         flag_q <= set_i;
         src_q  <= set_i & byp_i;
      end else if (set_i) begin
         flag_q <= 1'b1;
         src_q  <= byp_i;
      end else if (vid_rise_i && src_q) begin
         flag_q <= 1'b0;
         src_q  <= 1'b0;
      end
   end

   assign flag_o = flag_q;

   AST_BYP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (src_q && vid_rise_i && !set_i) |=> !flag_q); // R10
endmodule

// File: rtl/link_err_ctrl.sv
module link_err_ctrl #(
   parameter int CNT_W       = 8,
   parameter bit ERR_OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dec_err_i,
   input  logic             par_err_i,
   input  logic             prbs_mis_i,
   input  logic             video_ph_i,
   input  logic             ctrl_ph_i,
   input  logic             bypass_i,
   input  logic             prbs_en_i,
   input  logic             auto_clr_i,
   input  logic             rd_dec_i,
   input  logic             rd_par_i,
   output logic [CNT_W-1:0] dec_cnt_o,
   output logic [CNT_W-1:0] par_cnt_o,
   output logic [CNT_W-1:0] prbs_cnt_o,
   output logic             err_n_o
);
   initial begin
      if (CNT_W < 2 || CNT_W > 31) $error("link_err_ctrl: CNT_W out of range");
   end

   logic cc_end, vid_rise, auto_clr, par_set, err_any;

   lerr_edge #(.RISE(1'b0)) u_cc_edge (
      .clk(clk), .rst_n(rst_n), .sig_i(ctrl_ph_i), .edge_o(cc_end));
   lerr_edge #(.RISE(1'b1)) u_vid_edge (
      .clk(clk), .rst_n(rst_n), .sig_i(video_ph_i), .edge_o(vid_rise));

   assign auto_clr = auto_clr_i & cc_end;
   assign par_set  = par_err_i & ~(bypass_i & ~auto_clr_i);

   lerr_sat_cnt #(.W(CNT_W)) u_dec_cnt (
      .clk(clk), .rst_n(rst_n), .clr_i(rd_dec_i | auto_clr),
      .inc_i(dec_err_i), .cnt_o(dec_cnt_o));
   lerr_sat_cnt #(.W(CNT_W)) u_par_cnt (
      .clk(clk), .rst_n(rst_n), .clr_i(rd_par_i | auto_clr),
      .inc_i(par_err_i), .cnt_o(par_cnt_o));
   lerr_sat_cnt #(.W(CNT_W)) u_prbs_cnt (
      .clk(clk), .rst_n(rst_n), .clr_i(~prbs_en_i),
      .inc_i(prbs_en_i & prbs_mis_i), .cnt_o(prbs_cnt_o));

   logic par_flag;
   lerr_par_flag u_par_flag (
      .clk(clk), .rst_n(rst_n), .set_i(par_set), .byp_i(bypass_i),
      .clr_i(rd_par_i | auto_clr), .vid_rise_i(vid_rise), .flag_o(par_flag));

   assign err_any = (dec_cnt_o != '0) | (prbs_cnt_o != '0) | par_flag;

   generate
      if (ERR_OUT_REG) begin : g_err_reg
         logic err_n_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) err_n_q <= 1'b1;
            else        err_n_q <= ~err_any;
         end
         assign err_n_o = err_n_q;
      end else begin : g_err_comb
         assign err_n_o = ~err_any;
      end
   endgenerate

   AST_PRBS_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !prbs_en_i |=> prbs_cnt_o == '0); // R7
   AST_AUTO_KEEPS_PRBS: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_clr && prbs_en_i && !prbs_mis_i) |=> $stable(prbs_cnt_o)); // R5
   AST_AUTO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_clr && !dec_err_i) |=> dec_cnt_o == '0); // R4
   AST_DEC_HOLDS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_err_i && !rd_dec_i && !auto_clr) |=> dec_cnt_o != '0); // R8
endmodule

// File: tb/link_err_ctrl_tb.sv
module link_err_ctrl_tb_top;
   localparam int W = 8;
   localparam logic [W-1:0] MAX = '1;

   logic clk = 1'b0, rst_n = 1'b0;
   always #5 clk = ~clk;

   logic de, pe, pm, vid, cc, byp, en, aer, rdd, rdp;
   logic [W-1:0] dec_cnt, par_cnt, prbs_cnt;
   logic err_n;

   link_err_ctrl #(.CNT_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .dec_err_i(de), .par_err_i(pe), .prbs_mis_i(pm),
      .video_ph_i(vid), .ctrl_ph_i(cc), .bypass_i(byp), .prbs_en_i(en),
      .auto_clr_i(aer), .rd_dec_i(rdd), .rd_par_i(rdp),
      .dec_cnt_o(dec_cnt), .par_cnt_o(par_cnt), .prbs_cnt_o(prbs_cnt), .err_n_o(err_n));

   typedef struct {
      string        tag;
      logic [W-1:0] dec, par, prbs;
      logic         errn;
   } exp_t;
   exp_t q[$];

   int tests = 0, fails = 0;
   bit done = 1'b0;

   // reference state
   logic [W-1:0] m_dec = '0, m_par = '0, m_prbs = '0;
   logic m_flag = 0, m_src = 0, m_cc_q = 0, m_vid_q = 0;
   logic g_vid = 0, g_cc = 0, g_byp = 0, g_en = 0, g_aer = 0;

   function automatic logic [W-1:0] nxt(logic [W-1:0] c, logic clr, logic inc);
      if (clr) return inc ? W'(1) : '0;
      if (inc && c != MAX) return c + W'(1);
      return c;
   endfunction

   task automatic step(string tag, bit d = 0, bit p = 0, bit m = 0, bit rd = 0, bit rp = 0);
      exp_t e;
      logic aclr, vr, pset;
      @(negedge clk);
      de = d; pe = p; pm = m; rdd = rd; rdp = rp;
      vid = g_vid; cc = g_cc; byp = g_byp; en = g_en; aer = g_aer;
      aclr = g_aer && m_cc_q && !g_cc;
      vr   = g_vid && !m_vid_q;
      pset = p && !(g_byp && !g_aer);
      m_dec  = nxt(m_dec, rd || aclr, d);
      m_par  = nxt(m_par, rp || aclr, p);
      m_prbs = nxt(m_prbs, !g_en, g_en && m);
      if (rp || aclr) begin m_flag = pset; m_src = pset && g_byp; end
      else if (pset) begin m_flag = 1; m_src = g_byp; end
      else if (vr && m_src) begin m_flag = 0; m_src = 0; end
      m_cc_q = g_cc; m_vid_q = g_vid;
      e.tag = tag; e.dec = m_dec; e.par = m_par; e.prbs = m_prbs;
      e.errn = !(m_dec != 0 || m_prbs != 0 || m_flag);
      q.push_back(e);
   endtask

   // monitor: compares each expected item after the edge that produces it
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            tests++;
            if (dec_cnt !== e.dec || par_cnt !== e.par || prbs_cnt !== e.prbs || err_n !== e.errn) begin
               fails++;
               $display("FAIL %s: got dec=%0d par=%0d prbs=%0d err_n=%0b exp dec=%0d par=%0d prbs=%0d err_n=%0b",
                        e.tag, dec_cnt, par_cnt, prbs_cnt, err_n, e.dec, e.par, e.prbs, e.errn);
            end
         end
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got hang exp completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      {de, pe, pm, vid, cc, byp, en, aer, rdd, rdp} = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #3;
      tests++;
      if (dec_cnt !== 0 || par_cnt !== 0 || prbs_cnt !== 0 || err_n !== 1'b1) begin
         fails++;
         $display("FAIL R12: got %0d %0d %0d %0b exp 0 0 0 1", dec_cnt, par_cnt, prbs_cnt, err_n);
      end
      g_vid = 1;
      // R1 / R8 decode counting
      step("R1", 1); step("R1", 1); step("R1", 1); step("R8");
      // R2 read clear, then read coinciding with event
      step("R2", 0, 0, 0, 1); step("R2", 1, 0, 0, 1); step("R2", 0, 0, 0, 1);
      // R3 accumulate across control channel without auto-clear
      step("R3", 1); g_vid = 0; g_cc = 1; step("R3"); step("R3");
      g_cc = 0; g_vid = 1; step("R3"); step("R3", 1);
      // parity outside bypass
      step("R8", 0, 1); step("R8", 0, 1);
      // R4 auto-clear at control channel end, with event on the end cycle
      g_aer = 1; g_vid = 0; g_cc = 1; step("R4"); step("R4");
      g_cc = 0; step("R4", 0, 1); g_vid = 1; step("R4");
      step("R2", 0, 0, 0, 0, 1);
      // R6 pattern test counting, gated by enable
      g_en = 1; step("R6", 0, 0, 1); step("R6", 0, 0, 1); step("R6", 0, 0, 1);
      // R5 auto-clear keeps pattern count
      g_vid = 0; g_cc = 1; step("R5", 1); g_cc = 0; step("R5"); g_vid = 1; step("R5");
      // R7 disable clears and releases
      g_en = 0; step("R7"); step("R6", 0, 0, 1); step("R7");
      // R9 bypass, auto-clear off: counted but not flagged
      g_aer = 0; g_byp = 1; step("R9", 0, 1); step("R9");
      step("R9", 0, 0, 0, 0, 1);
      // R10 bypass, auto-clear on: flagged until next video phase start
      g_aer = 1; g_vid = 0; step("R10", 0, 1); step("R10");
      g_vid = 1; step("R10"); step("R10");
      step("R10", 0, 0, 0, 0, 1); g_byp = 0;
      // R11 saturation of decode and pattern registers
      g_en = 1;
      for (int i = 0; i < 260; i++) step("R11", 1, 0, 1);
      step("R11"); step("R2", 0, 0, 0, 1); g_en = 0; step("R7"); step("R12");
      repeat (3) @(posedge clk);
      #3;
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule